// File: doc/BRIEF.md
# Stride Result Validator

This block sits at the commit stage of a core that runs a leading copy and a trailing copy of the same program to detect errors. For every result that the leading copy commits, it predicts the value from a per-instruction stride history. If the actual result equals that prediction, the trailing copy can skip running the instruction. If the result differs, or there is no confident history, the trailing copy has to execute the instruction again.

Each table entry is selected directly by low instruction-address bits. An entry holds:

- an address tag;
- the last committed value;
- a narrow signed stride;
- a small saturating confidence counter.

The prediction is the last value plus the sign-extended stride. The lookup is combinational in the commit cycle. The table is written at the clock edge that closes the commit cycle.

Top module: `stride_result_validator`

## Requirements
- R1: After reset every entry is empty. The first commit at any address after reset gives `validated_o`=0, `redo_o`=1 and `expected_o`=0.
- R2: The entry index is commit_pc_i[13:2] (4096 entries, 4-byte aligned addresses). The tag is commit_pc_i[31:14]. Two addresses that share an index but differ in tag replace each other's entry.
- R3: When the indexed entry is valid and its tag matches, `expected_o` equals the stored last value plus the 16-bit two's complement stride, sign-extended to 32 bits. Otherwise `expected_o` is 0.
- R4: `validated_o` is 1 only when all of these hold: `commit_valid_i` is 1, the tag matches, confidence is at its maximum (3), and `commit_result_i` equals `expected_o`.
- R5: A hit whose result differs from the prediction does the following. It gives `redo_o`=1 and resets confidence to 0. It sets the stride to the result minus the last value, and it sets the last value to the result.
- R6: A hit whose result equals the prediction increments confidence, saturating at 3, and stores the result as the last value. With a steady stride, the first validation therefore comes on the sixth commit at an address. With a zero stride it comes on the fifth.
- R7: On a hit where the result minus the last value is outside [-32768, 32767], confidence and stride are both set to 0. Differences of exactly 32767 and -32768 are stored as strides.
- R8: A miss reallocates the entry with the new tag, the result as the last value, a zero stride and zero confidence.
- R9: The table changes only at a rising clock edge at which `commit_valid_i` is 1. Cycles with `commit_valid_i`=0 leave every entry unchanged, whatever the values on address and result.
- R10: `redo_o` = `commit_valid_i` and not `validated_o`. With `commit_valid_i`=0, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_valid_i | input | 1 | A leading-copy result commits this cycle |
| commit_pc_i | input | 32 | Address of the committing instruction |
| commit_result_i | input | 32 | Committed result value |
| validated_o | output | 1 | The result matched a confident prediction; the trailing copy may skip it |
| redo_o | output | 1 | The trailing copy must execute this instruction |
| expected_o | output | 32 | Predicted result for the addressed entry, or 0 on a miss |

## Verification
The assertions assume that `commit_pc_i` and `commit_result_i` are stable and known throughout any cycle in which `commit_valid_i` is high. They also assume that one commit is presented per cycle at most. The bench drives every input on the falling edge and holds it across the rising edge, so that assumption holds. Each scenario uses its own table index so that earlier training cannot leak into it. The aliasing scenario is the exception: it picks two addresses that share an index on purpose.

// File: rtl/svld_pkg.sv
package svld_pkg;
  typedef enum logic [1:0] {
    UPD_ALLOC   = 2'd0,
    UPD_TRAIN   = 2'd1,
    UPD_RELEARN = 2'd2,
    UPD_FLUSH   = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/svld_index.sv
module svld_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int ALIGN  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign idx_o = pc_i[ALIGN +: IDX_W];
  assign tag_o = pc_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/svld_table.sv
module svld_table #(
  parameter int IDX_W    = 12,
  parameter int TAG_W    = 18,
  parameter int DATA_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int CONF_W   = 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                rd_vld_o,
  output logic [TAG_W-1:0]    rd_tag_o,
  output logic [DATA_W-1:0]   rd_last_o,
  output logic [STRIDE_W-1:0] rd_stride_o,
  output logic [CONF_W-1:0]   rd_conf_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  logic [DATA_W-1:0]   wr_last_i,
  input  logic [STRIDE_W-1:0] wr_stride_i,
  input  logic [CONF_W-1:0]   wr_conf_i
);
  // only the valid bits are reset; payload arrays are plain storage
  logic [ENTRIES-1:0]  vld_q;
  logic [TAG_W-1:0]    tag_q    [ENTRIES];
  logic [DATA_W-1:0]   last_q   [ENTRIES];
  logic [STRIDE_W-1:0] stride_q [ENTRIES];
  logic [CONF_W-1:0]   conf_q   [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]    <= wr_tag_i;
      last_q[wr_idx_i]   <= wr_last_i;
      stride_q[wr_idx_i] <= wr_stride_i;
      conf_q[wr_idx_i]   <= wr_conf_i;
    end
  end

  assign rd_vld_o    = vld_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_last_o   = last_q[rd_idx_i];
  assign rd_stride_o = stride_q[rd_idx_i];
  assign rd_conf_o   = conf_q[rd_idx_i];
endmodule

// File: rtl/svld_predict.sv
module svld_predict
  import svld_pkg::*;
#(
  parameter int TAG_W    = 18,
  parameter int DATA_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int CONF_W   = 2
) (
  input  logic                commit_valid_i,
  input  logic [DATA_W-1:0]   result_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic                ent_vld_i,
  input  logic [TAG_W-1:0]    ent_tag_i,
  input  logic [DATA_W-1:0]   ent_last_i,
  input  logic [STRIDE_W-1:0] ent_stride_i,
  input  logic [CONF_W-1:0]   ent_conf_i,
  output logic                hit_o,
  output logic                validated_o,
  output logic                redo_o,
  output logic [DATA_W-1:0]   expected_o,
  output upd_kind_e           kind_o,
  output logic [STRIDE_W-1:0] new_stride_o,
  output logic [CONF_W-1:0]   new_conf_o
);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  logic [DATA_W-1:0] stride_sx, pred, diff;
  logic              match, fits;

  assign stride_sx = {{(DATA_W-STRIDE_W){ent_stride_i[STRIDE_W-1]}}, ent_stride_i};
  assign pred      = ent_last_i + stride_sx;
  assign diff      = result_i - ent_last_i;

  // difference fits the stride field when all bits above the sign bit copy it
  generate
    if (DATA_W > STRIDE_W) begin : g_rng
      assign fits = (diff[DATA_W-1:STRIDE_W-1] == '0) || (diff[DATA_W-1:STRIDE_W-1] == '1);
    end else begin : g_full
      assign fits = 1'b1;
    end
  endgenerate

  assign hit_o       = ent_vld_i && (ent_tag_i == tag_i);
  assign expected_o  = hit_o ? pred : '0;
  assign match       = hit_o && (result_i == pred);
  assign validated_o = commit_valid_i && match && (ent_conf_i == CONF_MAX);
  assign redo_o      = commit_valid_i && !validated_o;

  always_comb begin
    kind_o       = UPD_ALLOC;
    new_stride_o = '0;
    new_conf_o   = '0;
    if (hit_o) begin
      if (!fits) begin
        kind_o = UPD_FLUSH;
      end else if (match) begin
        kind_o       = UPD_TRAIN;
        new_stride_o = ent_stride_i;
        new_conf_o   = (ent_conf_i == CONF_MAX) ? CONF_MAX : ent_conf_i + 1'b1;
      end else begin
        kind_o       = UPD_RELEARN;
        new_stride_o = diff[STRIDE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/stride_result_validator.sv
module stride_result_validator
  import svld_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 12,
  parameter int ALIGN    = 2,
  parameter int STRIDE_W = 16,
  parameter int CONF_W   = 2,
  localparam int TAG_W   = ADDR_W - IDX_W - ALIGN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_valid_i,
  input  logic [ADDR_W-1:0] commit_pc_i,
  input  logic [DATA_W-1:0] commit_result_i,
  output logic              validated_o,
  output logic              redo_o,
  output logic [DATA_W-1:0] expected_o
);
  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic                rd_vld;
  logic [TAG_W-1:0]    rd_tag;
  logic [DATA_W-1:0]   rd_last;
  logic [STRIDE_W-1:0] rd_stride;
  logic [CONF_W-1:0]   rd_conf;
  logic                hit;
  upd_kind_e           kind;
  logic [STRIDE_W-1:0] new_stride;
  logic [CONF_W-1:0]   new_conf;

  svld_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_index (
    .pc_i  (commit_pc_i),
    .idx_o (idx),
    .tag_o (tag)
  );

  svld_table #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .STRIDE_W(STRIDE_W), .CONF_W(CONF_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (idx),
    .rd_vld_o    (rd_vld),
    .rd_tag_o    (rd_tag),
    .rd_last_o   (rd_last),
    .rd_stride_o (rd_stride),
    .rd_conf_o   (rd_conf),
    .wr_en_i     (commit_valid_i),
    .wr_idx_i    (idx),
    .wr_tag_i    (tag),
    .wr_last_i   (commit_result_i),
    .wr_stride_i (new_stride),
    .wr_conf_i   (new_conf)
  );

  svld_predict #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .STRIDE_W(STRIDE_W), .CONF_W(CONF_W)
  ) u_predict (
    .commit_valid_i (commit_valid_i),
    .result_i       (commit_result_i),
    .tag_i          (tag),
    .ent_vld_i      (rd_vld),
    .ent_tag_i      (rd_tag),
    .ent_last_i     (rd_last),
    .ent_stride_i   (rd_stride),
    .ent_conf_i     (rd_conf),
    .hit_o          (hit),
    .validated_o    (validated_o),
    .redo_o         (redo_o),
    .expected_o     (expected_o),
    .kind_o         (kind),
    .new_stride_o   (new_stride),
    .new_conf_o     (new_conf)
  );
endmodule

// File: rtl/svld_chk.sv
module svld_chk #(
  parameter int DATA_W = 32,
  parameter int CONF_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_valid_i,
  input logic [DATA_W-1:0] commit_result_i,
  input logic              validated_o,
  input logic              redo_o,
  input logic [DATA_W-1:0] expected_o,
  input logic              rd_vld,
  input logic [CONF_W-1:0] rd_conf
);
  // R4
  valid_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    validated_o |-> commit_valid_i);

  // R4
  valid_needs_conf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    validated_o |-> (rd_vld && rd_conf == {CONF_W{1'b1}}));

  // R5
  mismatch_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && commit_result_i != expected_o) |-> !validated_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_valid_i |-> (!validated_o && !redo_o));

  // R10
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(validated_o && redo_o));
endmodule

bind stride_result_validator svld_chk #(.DATA_W(DATA_W), .CONF_W(CONF_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .commit_valid_i  (commit_valid_i),
  .commit_result_i (commit_result_i),
  .validated_o     (validated_o),
  .redo_o          (redo_o),
  .expected_o      (expected_o),
  .rd_vld          (rd_vld),
  .rd_conf         (rd_conf)
);

// File: tb/stride_result_validator_tb.sv
module stride_result_validator_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        commit_valid_i = 1'b0;
  logic [31:0] commit_pc_i = '0;
  logic [31:0] commit_result_i = '0;
  logic        validated_o, redo_o;
  logic [31:0] expected_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        got_val, got_redo;
  logic [31:0] got_exp;

  always #10 clk_i = ~clk_i; // 50 MHz

  stride_result_validator u_dut (
    .clk_i, .rst_ni, .commit_valid_i, .commit_pc_i, .commit_result_i,
    .validated_o, .redo_o, .expected_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive on falling edge, sample before the next rising edge
  task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] res);
    @(negedge clk_i);
    commit_valid_i  = v;
    commit_pc_i     = pc;
    commit_result_i = res;
    #1;
    got_val  = validated_o;
    got_redo = redo_o;
    got_exp  = expected_o;
  endtask

  task automatic idle();
    @(negedge clk_i);
    commit_valid_i = 1'b0;
  endtask

  task automatic test_reset();
    step(1'b1, 32'h0000_0040, 32'h1234);
    chk(!got_val, "R1", "validated first commit", 32'(got_val), 0);
    chk(got_redo, "R1", "redo first commit", 32'(got_redo), 1);
    chk(got_exp == 0, "R1", "expected on empty", got_exp, 0);
    idle();
  endtask

  task automatic test_constant();
    for (int i = 1; i <= 4; i++) begin
      step(1'b1, 32'h100, 32'h55);
      chk(!got_val, "R6", "const early validated", 32'(got_val), 0);
    end
    step(1'b1, 32'h100, 32'h55);
    chk(got_val && !got_redo, "R6", "const 5th validated", 32'(got_val), 1);
    chk(got_exp == 32'h55, "R3", "const expected", got_exp, 32'h55);
    idle();
  endtask

  task automatic test_stride_mismatch();
    step(1'b1, 32'h200, 10);
    step(1'b1, 32'h200, 18);
    step(1'b1, 32'h200, 26);
    chk(got_exp == 26, "R3", "learned stride expected", got_exp, 26);
    chk(!got_val, "R4", "conf 0 not validated", 32'(got_val), 0);
    step(1'b1, 32'h200, 34);
    step(1'b1, 32'h200, 42);
    chk(!got_val, "R6", "5th not validated", 32'(got_val), 0);
    step(1'b1, 32'h200, 50);
    chk(got_val, "R6", "6th validated", 32'(got_val), 1);
    step(1'b1, 32'h200, 60);
    chk(got_redo && !got_val, "R5", "mismatch redo", 32'(got_redo), 1);
    chk(got_exp == 58, "R5", "mismatch expected", got_exp, 58);
    step(1'b1, 32'h200, 70);
    chk(got_exp == 70, "R5", "relearned stride", got_exp, 70);
    chk(!got_val, "R5", "conf reset after mismatch", 32'(got_val), 0);
    idle();
  endtask

  task automatic test_negative();
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 32'h300, 32'(1000 - 4*i));
      if (i == 2) chk(got_exp == 992, "R3", "negative stride expected", got_exp, 992);
    end
    chk(!got_val, "R6", "neg 5th", 32'(got_val), 0);
    step(1'b1, 32'h300, 980);
    chk(got_val, "R6", "neg 6th validated", 32'(got_val), 1);
    idle();
  endtask

  task automatic test_range();
    step(1'b1, 32'h400, 0);
    step(1'b1, 32'h400, 32767);
    step(1'b1, 32'h400, 65534);
    chk(got_exp == 65534, "R7", "max positive stride kept", got_exp, 65534);
    step(1'b1, 32'h600, 40000);
    step(1'b1, 32'h600, 7232);
    step(1'b1, 32'h600, 0);
    chk(got_exp == 32'(7232) - 32'd32768, "R7", "min negative stride kept",
        got_exp, 32'(7232) - 32'd32768);
    step(1'b1, 32'h500, 0);
    step(1'b1, 32'h500, 32768);
    step(1'b1, 32'h500, 32768);
    chk(got_exp == 32768, "R7", "out of range stride zeroed", got_exp, 32768);
    step(1'b1, 32'h500, 32768);
    step(1'b1, 32'h500, 32768);
    chk(!got_val, "R7", "conf reset out of range", 32'(got_val), 0);
    step(1'b1, 32'h500, 32768);
    chk(got_val, "R7", "retrained after range reset", 32'(got_val), 1);
    idle();
  endtask

  task automatic test_alias();
    for (int i = 0; i < 5; i++) step(1'b1, 32'h0000_0700, 32'h77);
    chk(got_val, "R2", "alias A trained", 32'(got_val), 1);
    step(1'b1, 32'h0000_4700, 32'h9);
    chk(got_redo && got_exp == 0, "R2", "alias B misses", got_exp, 0);
    step(1'b1, 32'h0000_0700, 32'h77);
    chk(got_redo && got_exp == 0, "R2", "alias A evicted", got_exp, 0);
    step(1'b1, 32'h0000_0700, 32'h77);
    chk(got_exp == 32'h77 && !got_val, "R8", "realloc last value, conf 0", got_exp, 32'h77);
    idle();
  endtask

  task automatic test_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 32'h800, 32'h33);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 32'h800, 32'h99);
      chk(!got_val && !got_redo, "R10", "idle flags low", {got_val, got_redo}, 0);
    end
    step(1'b1, 32'h800, 32'h33);
    chk(got_val && got_exp == 32'h33, "R9", "entry untouched by idle", got_exp, 32'h33);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_constant();
    test_stride_mismatch();
    test_negative();
    test_range();
    test_alias();
    test_idle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule